// File: doc/BRIEF.md
# Reconfigurable Multicast Scatter Tree

This block carries data words from a single buffer-side port down to a row of `N` leaf ports through a binary tree of small switch stages. Every word carries a destination bitmask in which bit `i` addresses leaf `i`. At each internal node the mask is OR-reduced over the lower and the upper half of the leaves under that node. This gives two branch enables, and only the addressed branches receive the word. A single-bit mask is a unicast, a sparse mask is a multicast and an all-ones mask is a broadcast. Links that lead to no addressed leaf hold their previous value.

The routing mask has two sources. In per-word mode the mask arrives with each word, so the routing can change from one cycle to the next. In epoch mode a mask captured earlier by a load strobe is used for every word, and the mask that arrives with the word is ignored. Each tree level holds one register stage. Flow control is a plain on/off signal: a stage advances only when every child it must feed can take the word. No credit counters are kept.

Top module: `scatter_tree`

## Requirements
- R1: While reset is held and in the first cycle after it, `leaf_valid` is all zeros and `in_ready` is 1.
- R2: In per-word mode, a word accepted at the root (`in_valid` and `in_ready` both high at a rising edge) is delivered exactly once, with its data unchanged, to every leaf `i` whose bit `i` of `in_mask` is 1. Leaf `i` data occupies `leaf_data[i*W +: W]`.
- R3: An all-ones mask delivers the word to every leaf.
- R4: A word whose effective mask is all zeros is accepted at once (`in_ready` is 1) and reaches no leaf.
- R5: When `cfg_epoch` is 1, the held mask decides the destinations and `in_mask` has no effect.
- R6: A `cfg_load` pulse captures `cfg_mask` into the held mask, and the new value applies to words accepted from the next cycle on. In per-word mode a load does not change routing.
- R7: While `leaf_valid[i]` and `leaf_off[i]` are both 1, leaf `i` keeps its valid and its data unchanged. A leaf word is consumed at a rising edge where `leaf_off[i]` is 0.
- R8: Under any backpressure pattern, no word is lost or duplicated, and each leaf receives its words in acceptance order.
- R9: With no backpressure and an empty tree, a word accepted at a rising edge is shown at its leaves after the `log2(N)`-th rising edge, counting the accepting edge as the first.
- R10: `leaf_data[i]` changes only when leaf `i` is given a new word. Unaddressed leaves do not toggle.
- R11: A blocked leaf stalls only the words that address it. Once the path to that leaf is full (`log2(N)` words), `in_ready` is 0 for a further word addressing it and 1 for a word addressing only leaves in other half-trees.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Root word present |
| in_data | input | W | Root word data |
| in_mask | input | N | Destination leaves of the root word (per-word mode) |
| in_ready | output | 1 | Root accepts the word at this edge |
| cfg_epoch | input | 1 | 1 selects the held mask, 0 selects the per-word mask |
| cfg_load | input | 1 | Capture strobe for the held mask |
| cfg_mask | input | N | Value captured by `cfg_load` |
| leaf_valid | output | N | Word present at each leaf |
| leaf_data | output | N*W | Leaf data, leaf `i` at bits `i*W +: W` |
| leaf_off | input | N | Per-leaf off signal, 1 holds the leaf word |

## Verification
The corner cases are an all-zero mask, single-bit masks at both edges of the leaf row, broadcast, and epoch masks that contradict the per-word mask. Each runs under random on/off backpressure. A fork that advanced when only one enabled child was free would deliver a word twice or drop it, and the per-leaf order scoreboard reports this. A zero mask that was not consumed at the root would hang the input. An epoch mode that leaked the per-word mask would send words to the wrong leaves. The path-full test blocks one leaf and sends a word to the other half-tree. A single global stall would show up there as a refused word, and a bus-like broadcast would show up as toggling data on leaves that were not addressed.

// File: rtl/st_pkg.sv
package st_pkg;

    typedef enum logic {
        ROUTE_PER_WORD = 1'b0,
        ROUTE_EPOCH    = 1'b1
    } route_mode_e;

    // floor(log2(v)) for v >= 1
    function automatic int flog2(input int v);
        int r;
        r = 0;
        for (int b = 0; b < 31; b++) begin
            if ((v >> b) > 1) r = b + 1;
        end
        return r;
    endfunction

    // leaves covered by node idx at tree level lvl in an n-leaf tree
    function automatic logic [63:0] leaf_span(input int n, input int lvl, input int idx);
        logic [63:0] res;
        int wid;
        int lo;
        wid = n >> lvl;
        lo  = idx * wid;
        for (int b = 0; b < 64; b++) begin
            res[b] = (b >= lo) && (b < lo + wid);
        end
        return res;
    endfunction

endpackage

// File: rtl/st_hold_cfg.sv
module st_hold_cfg #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [N-1:0] mask_in,
    output logic [N-1:0] mask_out
);

    logic [N-1:0] held_d, held_q;

    always_comb begin
        held_d = held_q;
        if (load) held_d = mask_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) held_q <= '0;
        else        held_q <= held_d;
    end

    assign mask_out = held_q;

endmodule

// File: rtl/st_fork.sv
module st_fork #(
    parameter int           N      = 8,
    parameter logic [N-1:0] COV_LO = '0,
    parameter logic [N-1:0] COV_HI = '0
) (
    input  logic         p_valid,
    input  logic [N-1:0] p_msk,
    input  logic         acc_lo,
    input  logic         acc_hi,
    output logic         p_ready,
    output logic         go_lo,
    output logic         go_hi
);

    logic en_lo, en_hi;

    always_comb begin
        en_lo   = |(p_msk & COV_LO);
        en_hi   = |(p_msk & COV_HI);
        // on/off rule: advance only if every enabled branch can take the word
        p_ready = (!en_lo || acc_lo) && (!en_hi || acc_hi);
        go_lo   = p_valid && p_ready && en_lo;
        go_hi   = p_valid && p_ready && en_hi;
    end

endmodule

// File: rtl/scatter_tree.sv
module scatter_tree
    import st_pkg::*;
#(
    parameter int N = 8,
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic [W-1:0]   in_data,
    input  logic [N-1:0]   in_mask,
    output logic           in_ready,
    input  logic           cfg_epoch,
    input  logic           cfg_load,
    input  logic [N-1:0]   cfg_mask,
    output logic [N-1:0]   leaf_valid,
    output logic [N*W-1:0] leaf_data,
    input  logic [N-1:0]   leaf_off
);

    localparam int LG    = $clog2(N);
    localparam int NODES = 2 * N;

    // heap numbering: node 1 is the root input, nodes 2..NODES-1 are registered,
    // nodes N..NODES-1 are the leaf registers (leaf i = node N+i)
    typedef struct packed {
        logic [NODES-1:2]          vld;
        logic [NODES-1:2][W-1:0]   dat;
        logic [N-1:2][N-1:0]       msk;
    } pipe_t;

    pipe_t st_d, st_q;

    logic [N-1:0] held_mask;
    logic [N-1:0] eff_mask;

    logic         par_vld [1:N-1];
    logic [W-1:0] par_dat [1:N-1];
    logic [N-1:0] par_msk [1:N-1];
    logic         rdy     [1:N-1];
    logic         acc     [2:NODES-1];
    logic         go      [2:NODES-1];
    logic         pop     [2:NODES-1];

    st_hold_cfg #(.N(N)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cfg_load),
        .mask_in  (cfg_mask),
        .mask_out (held_mask)
    );

    assign eff_mask = (route_mode_e'(cfg_epoch) == ROUTE_EPOCH) ? held_mask : in_mask;
    assign in_ready = rdy[1];

    for (genvar k = 1; k < N; k++) begin : g_node
        localparam int           LV    = $clog2(k + 1) - 1;
        localparam int           CIDX  = 2 * k - (1 << (LV + 1));
        localparam logic [63:0]  SP_LO = leaf_span(N, LV + 1, CIDX);
        localparam logic [63:0]  SP_HI = leaf_span(N, LV + 1, CIDX + 1);

        if (k == 1) begin : g_root
            assign par_vld[k] = in_valid;
            assign par_dat[k] = in_data;
            assign par_msk[k] = eff_mask;
        end else begin : g_mid
            assign par_vld[k] = st_q.vld[k];
            assign par_dat[k] = st_q.dat[k];
            assign par_msk[k] = st_q.msk[k];
            assign acc[k]     = !st_q.vld[k] || rdy[k];
            assign pop[k]     = st_q.vld[k] && rdy[k];
        end

        st_fork #(
            .N      (N),
            .COV_LO (SP_LO[N-1:0]),
            .COV_HI (SP_HI[N-1:0])
        ) u_fork (
            .p_valid (par_vld[k]),
            .p_msk   (par_msk[k]),
            .acc_lo  (acc[2*k]),
            .acc_hi  (acc[2*k+1]),
            .p_ready (rdy[k]),
            .go_lo   (go[2*k]),
            .go_hi   (go[2*k+1])
        );
    end

    for (genvar k = N; k < NODES; k++) begin : g_leaf
        assign acc[k]                   = !st_q.vld[k] || !leaf_off[k-N];
        assign pop[k]                   = st_q.vld[k] && !leaf_off[k-N];
        assign leaf_valid[k-N]          = st_q.vld[k];
        assign leaf_data[(k-N)*W +: W]  = st_q.dat[k];
    end

    always_comb begin
        logic [63:0] sp;
        st_d = st_q;
        sp   = '0;
        for (int k = 2; k < N; k++) begin
            sp = leaf_span(N, flog2(k), k - (1 << flog2(k)));
            if (go[k]) begin
                st_d.vld[k] = 1'b1;
                st_d.dat[k] = par_dat[k >> 1];
                st_d.msk[k] = par_msk[k >> 1] & sp[N-1:0];
            end else if (pop[k]) begin
                st_d.vld[k] = 1'b0;
            end
        end
        for (int k = N; k < NODES; k++) begin
            if (go[k]) begin
                st_d.vld[k] = 1'b1;
                st_d.dat[k] = par_dat[k >> 1];
            end else if (pop[k]) begin
                st_d.vld[k] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/scatter_tree_chk.sv
module scatter_tree_chk #(
    parameter int N = 8,
    parameter int W = 16
) (
    input logic           clk,
    input logic           rst_n,
    input logic           in_valid,
    input logic           in_ready,
    input logic [N-1:0]   eff_mask,
    input logic           cfg_load,
    input logic [N-1:0]   cfg_mask,
    input logic [N-1:0]   held_mask,
    input logic [N-1:0]   leaf_valid,
    input logic [N*W-1:0] leaf_data,
    input logic [N-1:0]   leaf_off
);

    // R4: an empty destination set is never stalled
    p_zero_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && eff_mask == '0) |-> in_ready);

    // R6: load strobe captures the configuration mask
    p_cfg_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load |=> (held_mask == $past(cfg_mask)));

    for (genvar i = 0; i < N; i++) begin : g_leaf_chk
        // R7: a held leaf keeps its word
        p_hold_vld_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (leaf_valid[i] && leaf_off[i]) |=> leaf_valid[i]);

        // R7: a held leaf keeps its data
        p_hold_dat_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (leaf_valid[i] && leaf_off[i]) |=> $stable(leaf_data[i*W +: W]));

        // R7: a leaf word leaves only on an edge where the leaf was on
        p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(leaf_valid[i]) |-> $past(!leaf_off[i]));

        // R10: leaf data only moves when a word is handed to that leaf
        p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(leaf_data[i*W +: W]) |-> leaf_valid[i]);
    end

endmodule

bind scatter_tree scatter_tree_chk #(.N(N), .W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .eff_mask   (eff_mask),
    .cfg_load   (cfg_load),
    .cfg_mask   (cfg_mask),
    .held_mask  (held_mask),
    .leaf_valid (leaf_valid),
    .leaf_data  (leaf_data),
    .leaf_off   (leaf_off)
);

// File: tb/scatter_tree_test.sv
`timescale 1ns/1ps
module scatter_tree_test;

    localparam int N  = 8;
    localparam int W  = 16;
    localparam int LG = 3;
    localparam int QD = 64;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           in_valid;
    logic [W-1:0]   in_data;
    logic [N-1:0]   in_mask;
    logic           in_ready;
    logic           cfg_epoch;
    logic           cfg_load;
    logic [N-1:0]   cfg_mask;
    logic [N-1:0]   leaf_valid;
    logic [N*W-1:0] leaf_data;
    logic [N-1:0]   leaf_off;

    always #2.5 clk = ~clk;

    scatter_tree #(.N(N), .W(W)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_mask(in_mask), .in_ready(in_ready), .cfg_epoch(cfg_epoch),
        .cfg_load(cfg_load), .cfg_mask(cfg_mask), .leaf_valid(leaf_valid),
        .leaf_data(leaf_data), .leaf_off(leaf_off)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [W-1:0] expq [N][QD];
    int           wp   [N];
    int           rp   [N];
    logic [N-1:0] held_m = '0;
    logic [N-1:0] got_mask;
    logic         epoch_sel = 1'b0;
    logic [W-1:0] seq = 16'h0100;

    // {req[3:0], epoch, cfg_mask[7:0], in_mask[7:0], expected leaves[7:0]}
    localparam logic [28:0] VEC [12] = '{
        {4'd2, 1'b0, 8'h00, 8'h01, 8'h01},  // R2 unicast low edge
        {4'd2, 1'b0, 8'h00, 8'h80, 8'h80},  // R2 unicast high edge
        {4'd3, 1'b0, 8'h00, 8'hFF, 8'hFF},  // R3 broadcast
        {4'd4, 1'b0, 8'h00, 8'h00, 8'h00},  // R4 nothing delivered
        {4'd2, 1'b0, 8'h00, 8'h5A, 8'h5A},  // R2 multicast
        {4'd5, 1'b1, 8'h3C, 8'h81, 8'h3C},  // R5 held mask wins
        {4'd5, 1'b1, 8'h00, 8'hFF, 8'h00},  // R5 held zero mask
        {4'd5, 1'b1, 8'hFF, 8'h00, 8'hFF},  // R5 held broadcast
        {4'd6, 1'b0, 8'hA5, 8'h24, 8'h24},  // R6 load ignored per word
        {4'd2, 1'b0, 8'h00, 8'h0F, 8'h0F},  // R2 lower half
        {4'd5, 1'b1, 8'h10, 8'hEF, 8'h10},  // R5 single leaf held
        {4'd2, 1'b0, 8'h00, 8'hF0, 8'hF0}   // R2 upper half
    };

    task automatic fail_line(input string req, input string what,
                             input logic [31:0] act, input logic [31:0] exp);
        fails++;
        $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    endtask

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) fail_line(req, what, act, exp);
    endtask

    // one clock cycle: drive at the falling edge, sample 1 ns later
    task automatic step(input logic v, input logic [W-1:0] d, input logic [N-1:0] m,
                        input logic [N-1:0] off, input logic ld, input logic [N-1:0] cm,
                        output logic acc);
        logic [N-1:0] eff;
        @(negedge clk);
        in_valid  = v;
        in_data   = d;
        in_mask   = m;
        leaf_off  = off;
        cfg_load  = ld;
        cfg_mask  = cm;
        cfg_epoch = epoch_sel;
        #1;
        for (int i = 0; i < N; i++) begin
            if (leaf_valid[i] && !off[i]) begin
                checks++;
                got_mask[i] = 1'b1;
                if (rp[i] == wp[i]) begin
                    fail_line("R8", $sformatf("extra word at leaf %0d", i),
                              32'(leaf_data[i*W +: W]), 32'hFFFFFFFF);
                end else begin
                    if (leaf_data[i*W +: W] !== expq[i][rp[i] % QD])
                        fail_line("R2", $sformatf("data/order at leaf %0d", i),
                                  32'(leaf_data[i*W +: W]), 32'(expq[i][rp[i] % QD]));
                    rp[i]++;
                end
            end
        end
        acc = v && in_ready;
        if (acc) begin
            eff = epoch_sel ? held_m : m;
            for (int i = 0; i < N; i++) begin
                if (eff[i]) begin
                    expq[i][wp[i] % QD] = d;
                    wp[i]++;
                end
            end
        end
        if (ld) held_m = cm;
    endtask

    task automatic drain(input string req);
        logic a;
        int left;
        for (int c = 0; c < 40; c++) step(1'b0, '0, '0, '0, 1'b0, '0, a);
        left = 0;
        for (int i = 0; i < N; i++) left += wp[i] - rp[i];
        chk(req, "words missing after drain", 32'(left), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R8 watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic a;
        logic [N*W-1:0] snap;
        int nacc;
        for (int i = 0; i < N; i++) begin wp[i] = 0; rp[i] = 0; end
        got_mask  = '0;
        rst_n     = 1'b0;
        in_valid  = 1'b0;
        in_data   = '0;
        in_mask   = '0;
        cfg_epoch = 1'b0;
        cfg_load  = 1'b0;
        cfg_mask  = '0;
        leaf_off  = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "leaf_valid in reset", 32'(leaf_valid), 32'd0);
        rst_n = 1'b1;
        #1;
        chk("R1", "leaf_valid after reset", 32'(leaf_valid), 32'd0);
        chk("R1", "in_ready after reset", 32'(in_ready), 32'd1);

        // R9 latency and R10 quiet links: unicast to leaf 3
        snap = leaf_data;
        step(1'b1, 16'hBEEF, 8'h08, '0, 1'b0, '0, a);
        chk("R9", "accept", 32'(a), 32'd1);
        for (int e = 1; e <= LG; e++) begin
            step(1'b0, '0, '0, '0, 1'b0, '0, a);
            chk("R9", $sformatf("leaf3 valid after edge %0d", e),
                32'(leaf_valid[3]), (e == LG) ? 32'd1 : 32'd0);
        end
        for (int i = 0; i < N; i++) begin
            if (i != 3)
                chk("R10", $sformatf("unaddressed leaf %0d data", i),
                    32'(leaf_data[i*W +: W]), 32'(snap[i*W +: W]));
        end
        drain("R8");

        // R4 zero mask consumed at the root
        step(1'b1, 16'h0BAD, 8'h00, '0, 1'b0, '0, a);
        chk("R4", "zero mask accepted", 32'(a), 32'd1);
        nacc = 0;
        for (int c = 0; c < LG + 3; c++) begin
            step(1'b0, '0, '0, '0, 1'b0, '0, a);
            if (leaf_valid != '0) nacc++;
        end
        chk("R4", "cycles with any leaf valid", 32'(nacc), 32'd0);

        // R11 and R7: leaf 0 blocked, path fills, other half still flows
        nacc = 0;
        for (int c = 0; c < 6; c++) begin
            step(1'b1, 16'hA000 + 16'(c), 8'h01, 8'h01, 1'b0, '0, a);
            if (a) nacc++;
        end
        chk("R11", "words accepted into blocked path", 32'(nacc), 32'(LG));
        chk("R11", "in_ready for blocked leaf", 32'(in_ready), 32'd0);
        step(1'b1, 16'hC0DE, 8'h80, 8'h01, 1'b0, '0, a);
        chk("R11", "word to other half accepted", 32'(a), 32'd1);
        for (int c = 0; c < 4; c++) begin
            step(1'b0, '0, '0, 8'h01, 1'b0, '0, a);
            chk("R7", "held leaf valid", 32'(leaf_valid[0]), 32'd1);
            chk("R7", "held leaf data", 32'(leaf_data[0 +: W]), 32'h0000A000);
        end
        drain("R8");

        // table walk
        for (int t = 0; t < 12; t++) begin
            logic [3:0] rq;
            rq        = VEC[t][28:25];
            epoch_sel = VEC[t][24];
            got_mask  = '0;
            step(1'b0, '0, '0, '0, 1'b1, VEC[t][23:16], a);
            for (int w = 0; w < 6; w++) begin
                a = 1'b0;
                while (!a) begin
                    step(1'b1, seq, VEC[t][15:8], N'($urandom & $urandom), 1'b0, '0, a);
                end
                seq++;
            end
            drain("R8");
            chk($sformatf("R%0d", rq), $sformatf("leaves reached, row %0d", t),
                32'(got_mask), 32'(VEC[t][7:0]));
        end

        // per-word masks changing every cycle under random backpressure (R8)
        epoch_sel = 1'b0;
        for (int c = 0; c < 400; c++) begin
            logic v;
            v = ($urandom % 4) != 0;
            step(v, seq, N'($urandom), N'($urandom & $urandom), 1'b0, '0, a);
            if (a) seq++;
        end
        drain("R8");
        chk("R8", "leaves idle after drain", 32'(leaf_valid), 32'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule